// File: doc/BRIEF.md
# Frame-Based Packet Write Aggregator

This block sits in front of an interleaved bank memory that is slower than the line. Fixed-size packets arrive at most one per time slot. Each packet carries its payload, the time slot in which it must later leave, a bank number that an external selector has already chosen, and a flag that marks it for the short-latency bypass path. Time is grouped into frames of `SLOTS` consecutive slots. The block keeps every packet that arrives in a frame on chip. In the next frame it issues one bank write command per slot for those packets, in the order they arrived, and meanwhile it collects the next frame's arrivals.

Two frame registers swap roles at the start of each frame, so one fills while the other drains. A write command carries the chosen bank, a row address and the departure slot, which is stored next to the payload so a later read stage can restore the order. The row is the departure frame, `floor(departure_slot / SLOTS)`, wrapped modulo `ROW_COUNT`. A packet flagged for bypass is not stored. It appears unchanged on the bypass outputs in the same cycle.

Top module: `fwa_frame_aggregator`

## Requirements
- R1: While reset is high, and in every slot of the first frame after reset is released, `wr_valid` is 0.
- R2: A packet accepted (`in_valid`=1, `in_bypass`=0) in slot k after reset release, where slot 0 is the first cycle with reset low, produces `wr_valid`=1 in slot k+SLOTS. This is the same position within the next frame.
- R3: The write command carries on `wr_bank` the bank number the packet arrived with on `in_bank`.
- R4: `wr_row` equals `(in_dep_slot / SLOTS) mod ROW_COUNT`, using integer division, for the packet being written. It is always below `ROW_COUNT`.
- R5: `wr_payload` and `wr_stamp` equal the payload and departure slot the packet arrived with.
- R6: A slot with `in_valid`=0 causes no write command SLOTS slots later.
- R7: A packet with `in_valid`=1 and `in_bypass`=1 shows `byp_valid`=1, with `byp_payload` and `byp_stamp` equal to its inputs, in the same slot. It causes no write command SLOTS slots later. `byp_valid` is 0 for any other input.
- R8: Frames filled back to back are written back to back. A full frame yields a write in every slot of the next frame while new arrivals are being captured.
- R9: Each stored packet is written exactly once. A slot with no capture in frame f+1 causes no write in frame f+2, even if frame f had a packet at that position.
- R10: Reset asserted in the middle of operation discards all held packets. No write command appears in the first frame after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A packet is present in this slot |
| in_bypass | input | 1 | Packet departs too soon and takes the bypass path |
| in_bank | input | BANK_W (3) | Bank picked by the external selector |
| in_payload | input | PAY_W (32) | Packet payload |
| in_dep_slot | input | STAMP_W (16) | Departure time slot of the packet |
| wr_valid | output | 1 | A bank write command is presented this slot |
| wr_bank | output | BANK_W (3) | Target bank of the write |
| wr_row | output | ROW_W (4) | Circular row address from the departure frame |
| wr_payload | output | PAY_W (32) | Payload to be written |
| wr_stamp | output | STAMP_W (16) | Departure slot written alongside the payload |
| byp_valid | output | 1 | A bypass packet is presented this slot |
| byp_payload | output | PAY_W (32) | Bypass packet payload |
| byp_stamp | output | STAMP_W (16) | Bypass packet departure slot |

## Verification
The hardest case to reach from the ports is a stale entry. A frame register that held a packet two frames ago is reused for an empty or bypass slot, and the old packet must not come out again. The stimulus table fills a frame completely, follows it with empty and bypass slots at the same positions, and then checks every slot of the frames that drain afterwards. A second case is reset arriving while one frame register is full. A directed sequence fills a frame, pulses reset, and then watches the whole first frame after the release for unwanted writes. Row wrapping is reached with departure slots that land on the last row, on row 0 after the wrap, and at the top of the timestamp range.

// File: rtl/fwa_pkg.sv
package fwa_pkg;

    localparam int PAY_W   = 32;
    localparam int STAMP_W = 16;
    localparam int BANK_W  = 3;
    localparam int ROW_W   = 4;

    typedef logic [PAY_W-1:0]   payload_t;
    typedef logic [STAMP_W-1:0] stamp_t;
    typedef logic [BANK_W-1:0]  bank_t;
    typedef logic [ROW_W-1:0]   row_t;

    // One held packet, ready to be turned into a bank write.
    typedef struct packed {
        logic     valid;
        bank_t    bank;
        row_t     row;
        payload_t payload;
        stamp_t   stamp;
    } slot_entry_t;

    // Departure frame index wrapped onto the row space of a bank.
    function automatic row_t frame_row(input stamp_t stamp,
                                       input int     slots,
                                       input int     rows);
        int frame_idx;
        int wrapped;
        frame_idx = int'(stamp) / slots;
        wrapped   = frame_idx % rows;
        return row_t'(wrapped);
    endfunction

endpackage

// File: rtl/fwa_slot_clock.sv
module fwa_slot_clock #(
    parameter int SLOTS = 3,
    localparam int PH_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            fill_sel
);

    localparam logic [PH_W-1:0] LAST = PH_W'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= '0;
            fill_sel <= 1'b0;
        end else if (phase == LAST) begin
            phase    <= '0;
            fill_sel <= ~fill_sel;
        end else begin
            phase    <= phase + 1'b1;
        end
    end

endmodule

// File: rtl/fwa_frame_store.sv
module fwa_frame_store
    import fwa_pkg::*;
#(
    parameter int SLOTS = 3,
    localparam int PH_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            fill_sel,
    input  logic [PH_W-1:0] phase,
    input  slot_entry_t     wr_entry,
    output slot_entry_t     rd_entry
);

    slot_entry_t half_q [2][SLOTS];
    slot_entry_t half_rd [2];

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int s = 0; s < SLOTS; s++) begin
                    half_q[h][s] <= '0;
                end
            end else if (fill_sel == 1'(h)) begin
                // every slot rewrites its entry, empty slots store valid=0
                half_q[h][phase] <= wr_entry;
            end
        end
        assign half_rd[h] = half_q[h][phase];
    end

    assign rd_entry = fill_sel ? half_rd[0] : half_rd[1];

endmodule

// File: rtl/fwa_bypass_tap.sv
module fwa_bypass_tap
    import fwa_pkg::*;
(
    input  logic     in_valid,
    input  logic     in_bypass,
    input  payload_t in_payload,
    input  stamp_t   in_stamp,
    output logic     capture,
    output logic     byp_valid,
    output payload_t byp_payload,
    output stamp_t   byp_stamp
);

    always_comb begin
        capture     = in_valid & ~in_bypass;
        byp_valid   = in_valid & in_bypass;
        byp_payload = in_payload;
        byp_stamp   = in_stamp;
    end

endmodule

// File: rtl/fwa_frame_aggregator.sv
module fwa_frame_aggregator
    import fwa_pkg::*;
#(
    parameter int SLOTS     = 3,
    parameter int ROW_COUNT = 12,
    localparam int PH_W     = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic                      in_bypass,
    input  logic [fwa_pkg::BANK_W-1:0]  in_bank,
    input  logic [fwa_pkg::PAY_W-1:0]   in_payload,
    input  logic [fwa_pkg::STAMP_W-1:0] in_dep_slot,
    output logic                      wr_valid,
    output logic [fwa_pkg::BANK_W-1:0]  wr_bank,
    output logic [fwa_pkg::ROW_W-1:0]   wr_row,
    output logic [fwa_pkg::PAY_W-1:0]   wr_payload,
    output logic [fwa_pkg::STAMP_W-1:0] wr_stamp,
    output logic                      byp_valid,
    output logic [fwa_pkg::PAY_W-1:0]   byp_payload,
    output logic [fwa_pkg::STAMP_W-1:0] byp_stamp
);

    logic [PH_W-1:0] phase;
    logic            fill_sel;
    logic            capture;
    slot_entry_t     new_entry;
    slot_entry_t     out_entry;

    fwa_slot_clock #(.SLOTS(SLOTS)) u_clock (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .fill_sel (fill_sel)
    );

    fwa_bypass_tap u_tap (
        .in_valid    (in_valid),
        .in_bypass   (in_bypass),
        .in_payload  (in_payload),
        .in_stamp    (in_dep_slot),
        .capture     (capture),
        .byp_valid   (byp_valid),
        .byp_payload (byp_payload),
        .byp_stamp   (byp_stamp)
    );

    always_comb begin
        new_entry.valid   = capture;
        new_entry.bank    = in_bank;
        new_entry.row     = frame_row(in_dep_slot, SLOTS, ROW_COUNT);
        new_entry.payload = in_payload;
        new_entry.stamp   = in_dep_slot;
    end

    fwa_frame_store #(.SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst      (rst),
        .fill_sel (fill_sel),
        .phase    (phase),
        .wr_entry (new_entry),
        .rd_entry (out_entry)
    );

    always_comb begin
        wr_valid   = out_entry.valid;
        wr_bank    = out_entry.bank;
        wr_row     = out_entry.row;
        wr_payload = out_entry.payload;
        wr_stamp   = out_entry.stamp;
    end

endmodule

// File: rtl/fwa_checker.sv
module fwa_checker #(
    parameter int SLOTS     = 3,
    parameter int ROW_COUNT = 12
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      in_valid,
    input logic                      in_bypass,
    input logic                      wr_valid,
    input logic [fwa_pkg::ROW_W-1:0] wr_row
);

    logic [SLOTS-1:0] hist;
    logic [31:0]      since_rst;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist      <= '0;
            since_rst <= '0;
        end else begin
            hist <= SLOTS'({hist, (in_valid && !in_bypass)});
            if (since_rst < 32'(SLOTS)) since_rst <= since_rst + 1'b1;
        end
    end

    p_quiet_first_frame_r1: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 32'(SLOTS)) |-> !wr_valid);

    p_capture_yields_write_r2: assert property (@(posedge clk) disable iff (rst)
        hist[SLOTS-1] |-> wr_valid);

    p_row_in_range_r4: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (32'(wr_row) < 32'(ROW_COUNT)));

    p_no_orphan_write_r6: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> hist[SLOTS-1]);

endmodule

bind fwa_frame_aggregator fwa_checker #(.SLOTS(SLOTS), .ROW_COUNT(ROW_COUNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_bypass (in_bypass),
    .wr_valid  (wr_valid),
    .wr_row    (wr_row)
);

// File: tb/fwa_frame_aggregator_test.sv
`timescale 1ns/1ps
module fwa_frame_aggregator_test;

    localparam int SLOTS = 3;
    localparam int ROWS  = 12;
    localparam int NVEC  = 18;

    // {valid, bypass, bank[2:0], payload[31:0], dep[15:0]}
    localparam logic [52:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 3'd1, 32'hA000_0000, 16'd40},
        {1'b1, 1'b0, 3'd4, 32'hA000_0001, 16'd35},
        {1'b1, 1'b0, 3'd6, 32'hA000_0002, 16'd36},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b1, 1'b1, 3'd0, 32'hB000_0004, 16'd5},
        {1'b1, 1'b0, 3'd2, 32'hA000_0005, 16'hFFFF},
        {1'b1, 1'b0, 3'd0, 32'hC000_0006, 16'd100},
        {1'b1, 1'b0, 3'd3, 32'hC000_0007, 16'd101},
        {1'b1, 1'b0, 3'd5, 32'hC000_0008, 16'd102},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b1, 1'b0, 3'd1, 32'hD000_000C, 16'd7},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b1, 1'b1, 3'd2, 32'hB000_000E, 16'd9},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0},
        {1'b0, 1'b0, 3'd0, 32'h0000_0000, 16'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_bypass = 1'b0;
    logic [2:0]  in_bank = '0;
    logic [31:0] in_payload = '0;
    logic [15:0] in_dep_slot = '0;
    logic        wr_valid;
    logic [2:0]  wr_bank;
    logic [3:0]  wr_row;
    logic [31:0] wr_payload;
    logic [15:0] wr_stamp;
    logic        byp_valid;
    logic [31:0] byp_payload;
    logic [15:0] byp_stamp;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    fwa_frame_aggregator #(.SLOTS(SLOTS), .ROW_COUNT(ROWS)) uut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_bypass(in_bypass), .in_bank(in_bank),
        .in_payload(in_payload), .in_dep_slot(in_dep_slot),
        .wr_valid(wr_valid), .wr_bank(wr_bank), .wr_row(wr_row),
        .wr_payload(wr_payload), .wr_stamp(wr_stamp),
        .byp_valid(byp_valid), .byp_payload(byp_payload), .byp_stamp(byp_stamp)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic drive(input logic [52:0] v);
        in_valid    = v[52];
        in_bypass   = v[51];
        in_bank     = v[50:48];
        in_payload  = v[47:16];
        in_dep_slot = v[15:0];
    endtask

    task automatic check_idle_write(input string tag);
        check(wr_valid == 1'b0, tag, 64'(wr_valid), 64'd0);
    endtask

    initial begin
        #100000;
        n_fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_idle_write("R1 during reset");

        @(posedge clk);
        #1 rst = 1'b0;

        // table walk: slot k drives VEC[k]; write expected from VEC[k-SLOTS]
        for (int k = 0; k < NVEC; k++) begin
            drive(VEC[k]);
            @(negedge clk);
            if (k < SLOTS) begin
                check_idle_write("R1 first frame");
            end else begin
                logic [52:0] p;
                logic        exp_wr;
                p = VEC[k - SLOTS];
                exp_wr = p[52] && !p[51];
                // R2 R6 R7 R8 R9: write presence follows capture one frame back
                check(wr_valid == exp_wr, "R2/R6/R7/R9 write presence",
                      64'(wr_valid), 64'(exp_wr));
                if (exp_wr) begin
                    logic [3:0] erow;
                    erow = 4'((int'(p[15:0]) / SLOTS) % ROWS);
                    check(wr_bank == p[50:48], "R3 bank", 64'(wr_bank), 64'(p[50:48]));
                    check(wr_row == erow, "R4 row", 64'(wr_row), 64'(erow));
                    check(wr_payload == p[47:16], "R5 payload",
                          64'(wr_payload), 64'(p[47:16]));
                    check(wr_stamp == p[15:0], "R5 stamp", 64'(wr_stamp), 64'(p[15:0]));
                end
            end
            begin
                logic exp_b;
                exp_b = VEC[k][52] && VEC[k][51];
                check(byp_valid == exp_b, "R7 bypass flag", 64'(byp_valid), 64'(exp_b));
                if (exp_b) begin
                    check(byp_payload == VEC[k][47:16], "R7 bypass payload",
                          64'(byp_payload), 64'(VEC[k][47:16]));
                    check(byp_stamp == VEC[k][15:0], "R7 bypass stamp",
                          64'(byp_stamp), 64'(VEC[k][15:0]));
                end
            end
            @(posedge clk);
            #1;
        end

        // R10: fill a frame, then reset before it can drain
        for (int k = 0; k < SLOTS; k++) begin
            drive({1'b1, 1'b0, 3'(k), 32'hE000_0000 + 32'(k), 16'(200 + k)});
            @(posedge clk);
            #1;
        end
        drive('0);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1 rst = 1'b0;
        for (int k = 0; k < 2 * SLOTS; k++) begin
            @(negedge clk);
            check_idle_write("R10 after mid-run reset");
            @(posedge clk);
            #1;
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule